// File: doc/BRIEF.md
# Quadrant Decoder with Instruction/Data Address Inversion

This block sits right after the logical-to-physical translator. Each cycle it can accept one 24-bit physical address together with the kind of access (instruction fetch or data access) and the logical segment that produced the address. It returns the final physical address and a 2-bit quadrant index, which a later chip-select stage uses. Two configuration bytes shape the result. The expansion byte decides which pair of address bits selects among the four quadrants. That pair can be placed anywhere from A18:A17 up to A23:A22, so the quadrant size runs from 128 KB to 4 MB.

The second byte controls the instruction/data split. When the split is on, data accesses in the base segment can have A16 inverted. Data accesses in the data segment can have the top quadrant-select bit inverted. Code and data can then share the same logical addresses and still land in different physical memory. Instruction fetches and accesses in the stack or extended segments always pass through unchanged. The result is registered, so every accepted request produces exactly one response one cycle later.

Top module: `quad_decode`

## Requirements
- R1: While reset is asserted and after it is released, with no request yet accepted, `rsp_valid`, `rsp_addr` and `rsp_quad` are all zero.
- R2: A request accepted with `req_valid` high at a clock edge produces exactly one response, with `rsp_valid` high after that same edge. `rsp_valid` is low after any edge where `req_valid` was low.
- R3: `cfg_qsel[7:5]` sets the top quadrant bit T, and the select pair is A(T):A(T-1). The codes map as follows: 111 gives T=18, 000 gives T=19, 001 gives T=20, 010 gives T=21, 011 gives T=22 and 100 gives T=23.
- R4: Codes 101 and 110 of `cfg_qsel[7:5]` behave exactly like code 000 (T=19).
- R5: When `cfg_split[5]` is 0, `rsp_addr` equals `req_addr` for every access.
- R6: An instruction fetch (`req_ifetch`=1) is never altered.
- R7: A data access with `req_seg`=00 (base), `cfg_split[5]`=1 and `cfg_split[0]`=1 has A16 inverted. All other bits are unchanged.
- R8: A data access with `req_seg`=01 (data), `cfg_split[5]`=1 and `cfg_split[3]`=1 has bit T inverted. For example, with T=19 and split byte 0x29, 0x003000 becomes 0x083000.
- R9: Accesses with `req_seg`=10 (stack) or 11 (extended window) are never altered.
- R10: `rsp_quad` equals bits T:T-1 of `rsp_addr`, taken after any inversion.
- R11: After an edge with `req_valid` low, `rsp_addr` and `rsp_quad` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 24 | Physical address from the translator |
| req_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_seg | input | 2 | Logical segment hit: 00 base, 01 data, 10 stack, 11 extended |
| cfg_qsel | input | 8 | Expansion byte; bits 7:5 choose the quadrant-select pair |
| cfg_split | input | 8 | Split byte; bit 5 enable, bit 0 A16 inversion, bit 3 top-bit inversion |
| rsp_valid | output | 1 | Response present |
| rsp_addr | output | 24 | Final physical address |
| rsp_quad | output | 2 | Quadrant index |

## Verification
Every result (valid flag, address and quadrant) is due one edge after the request edge. The driver applies requests on falling edges and pushes the independently computed address and quadrant into a queue at that moment. The monitor samples on the next falling edge, half a cycle after the response register updates, and pops one entry for each valid response. A leftover or missing entry exposes a latency error. The hold behaviour is checked by changing the request inputs over several idle cycles and confirming that the sampled outputs do not move.

// File: rtl/quad_decode.sv
module quad_decode #(
  parameter int AW = 24,
  parameter int FLIP_LOW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_ifetch,
  input  logic [1:0]    req_seg,
  input  logic [7:0]    cfg_qsel,
  input  logic [7:0]    cfg_split,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic [1:0]    rsp_quad
);

  localparam int TW = $clog2(AW);

  logic [TW-1:0] top;
  logic [AW-1:0] flip;
  logic [AW-1:0] adj;
  logic          split_on;

  always_comb begin
    case (cfg_qsel[7:5])
      3'b111:  top = TW'(18);
      3'b001:  top = TW'(20);
      3'b010:  top = TW'(21);
      3'b011:  top = TW'(22);
      3'b100:  top = TW'(23);
      default: top = TW'(19);
    endcase
  end

  assign split_on = cfg_split[5] && !req_ifetch;

  always_comb begin
    flip = '0;
    if (split_on && req_seg == 2'b00 && cfg_split[0]) flip[FLIP_LOW] = 1'b1;
    if (split_on && req_seg == 2'b01 && cfg_split[3]) flip[top] = 1'b1;
  end

  assign adj = req_addr ^ flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_quad  <= 2'b00;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_addr <= adj;
        rsp_quad <= {adj[top], adj[top - TW'(1)]};
      end
    end
  end

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid == $past(req_valid)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$past(req_valid) |-> ($stable(rsp_addr) && $stable(rsp_quad))); // R11
  AST_FETCH_PASS: assert property (@(posedge clk) disable iff (!rst_n) $past(req_valid && req_ifetch) |-> rsp_addr == $past(req_addr)); // R6
  AST_SPLIT_OFF: assert property (@(posedge clk) disable iff (!rst_n) $past(req_valid && !cfg_split[5]) |-> rsp_addr == $past(req_addr)); // R5
  AST_UPPER_SEGS: assert property (@(posedge clk) disable iff (!rst_n) $past(req_valid && req_seg[1]) |-> rsp_addr == $past(req_addr)); // R9
  AST_LOW_WORD: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> rsp_addr[FLIP_LOW-1:0] == $past(req_addr[FLIP_LOW-1:0])); // R7
  AST_FLIP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> $countones(rsp_addr ^ $past(req_addr)) <= 2); // R8

endmodule

// File: tb/quad_decode_test.sv
module quad_decode_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic        req_ifetch = 1'b0;
  logic [1:0]  req_seg = 2'b00;
  logic [7:0]  cfg_qsel = 8'h00;
  logic [7:0]  cfg_split = 8'h00;
  logic        rsp_valid;
  logic [23:0] rsp_addr;
  logic [1:0]  rsp_quad;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [25:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  quad_decode uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ifetch(req_ifetch), .req_seg(req_seg), .cfg_qsel(cfg_qsel),
    .cfg_split(cfg_split), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_quad(rsp_quad)
  );

  function automatic int top_bit(input logic [2:0] code);
    case (code)
      3'b111: return 18;
      3'b000: return 19;
      3'b001: return 20;
      3'b010: return 21;
      3'b011: return 22;
      3'b100: return 23;
      default: return 19;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] a, input logic f, input logic [1:0] s,
                      input logic [7:0] q, input logic [7:0] sp, input string tag);
    int t;
    logic [23:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_ifetch = f; req_seg = s;
    cfg_qsel = q; cfg_split = sp;
    t = top_bit(q[7:5]);
    e = a;
    if (sp[5] && !f) begin
      if (s == 2'b00 && sp[0]) e[16] = ~e[16];
      if (s == 2'b01 && sp[3]) e[t] = ~e[t];
    end
    exp_q.push_back({e, e[t], e[t-1]});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected response", 32'(rsp_valid), 32'd0);
      end else begin
        logic [25:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        check({tg, " addr"}, 32'(rsp_addr), 32'(e[25:2]));
        check({"R10 ", tg, " quad"}, 32'(rsp_quad), 32'(e[1:0]));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [23:0] held_a;
    logic [1:0]  held_q;
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(rsp_valid), 0);
    check("R1 reset addr", 32'(rsp_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset valid", 32'(rsp_valid), 0);
    check("R1 post-reset quad", 32'(rsp_quad), 0);

    send(24'h003000, 1'b0, 2'b01, 8'h00, 8'h29, "R8 example");
    for (int c = 0; c < 8; c++)
      send(24'h000000 ^ 24'(c * 24'h15A5A5), 1'b0, 2'b01, {3'(c), 5'h00}, 8'h29, "R3 R4 R8 code sweep");
    for (int c = 0; c < 8; c++)
      send(24'hFFFFFF ^ 24'(c * 24'h0C3C31), 1'b0, 2'b00, {3'(c), 5'h00}, 8'h21, "R3 R7 base seg");
    send(24'h0C1234, 1'b0, 2'b01, 8'hA0, 8'h29, "R4 code 101");
    send(24'h0C1234, 1'b0, 2'b01, 8'hC0, 8'h29, "R4 code 110");
    send(24'h013000, 1'b0, 2'b00, 8'h00, 8'h09, "R5 split off base");
    send(24'h053000, 1'b0, 2'b01, 8'h80, 8'h09, "R5 split off data");
    send(24'h013000, 1'b1, 2'b00, 8'h00, 8'h29, "R6 fetch base");
    send(24'h7A3000, 1'b1, 2'b01, 8'h60, 8'h29, "R6 fetch data");
    send(24'h0ED000, 1'b0, 2'b10, 8'h00, 8'h29, "R9 stack");
    send(24'h3FE000, 1'b0, 2'b11, 8'h40, 8'h29, "R9 xmem");
    send(24'h003000, 1'b0, 2'b01, 8'h00, 8'h21, "R7 data seg no bit3");
    send(24'h013000, 1'b0, 2'b00, 8'h00, 8'h28, "R8 base seg no bit0");
    idle(3);

    held_a = rsp_addr;
    held_q = rsp_quad;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      req_addr = 24'(i * 24'h2F1E3D) ^ 24'hABCDEF;
      req_seg = 2'(i);
      cfg_qsel = 8'(i * 8'h40);
      check("R11 hold addr", 32'(rsp_addr), 32'(held_a));
      check("R11 hold quad", 32'(rsp_quad), 32'(held_q));
      check("R2 idle valid", 32'(rsp_valid), 0);
    end

    idle(2);
    check("R2 queue drained", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule